// File: doc/BRIEF.md
# Memory Access Fault Arbiter and Fault Register File

This block sits beside the address-translation logic and decides, for every memory access, whether that access is aborted. The table walker, the translation cache and the access-permission lookup sit outside it. They hand in one flag per fault class, together with the access's domain number and whether the access resolved through a section or a page descriptor. The block qualifies each flag against the enables and the access type. It picks the most urgent qualified fault and returns an abort to the core in the same cycle. For a genuine violation it also withholds the outgoing bus request.

On the clock edge where an abort is raised, the block records the fault. A data-side abort writes the encoded status and the domain into a data status register and the access address into an address register. An instruction-fetch abort writes only an instruction status register. Software reads all three registers through a small combinational read port.

Top module: `mmu_fault_unit`

## Requirements
- R1: After reset, the data status register, the fault address register and the instruction status register all read zero, and no abort or bus request is signalled while `acc_valid` is low.
- R2: A data access (`acc_fetch`=0) with `flt_misalign` set while `align_en`=1 aborts with status 4'b0001 and domain 0, whatever the value of `mmu_en`.
- R3: `flt_misalign` has no effect on an instruction fetch, and no effect on any access while `align_en`=0.
- R4: Translation, domain and permission flags take effect only while `mmu_en`=1. Their status codes for a section / page descriptor (`desc_is_page`=0/1) are 4'b0101/4'b0111 for translation, 4'b1001/4'b1011 for domain and 4'b1101/4'b1111 for permission. Translation faults record domain 0. Domain and permission faults record `acc_domain`.
- R5: When several qualified sources are active, only the most urgent one is recorded. The order, most urgent first, is: alignment, walk external error, translation, domain, permission, final-access external error.
- R6: `ext_bus_err` is honoured only for synchronous access kinds: `acc_kind` 1 (uncached read), 2 (unbuffered write) or 3 (locked swap). Kind 0 ignores it. An honoured error records 4'b0100 when `acc_linefetch`=1 and 4'b1000 otherwise, with domain `acc_domain`.
- R7: `ext_walk_err` aborts with status 4'b1000 and domain 0 only while `mmu_en`=1. It is ignored otherwise.
- R8: `abort` is high in the same cycle as the faulting `acc_valid`. `bus_req` equals `acc_valid` except that it is held low when any source other than the final-access external error is active.
- R9: A data abort loads the data status register with {domain[3:0], status[3:0]} and loads the fault address register with `acc_addr`, on the clock edge of the abort.
- R10: An instruction-fetch abort raises `abort_prefetch` and loads the instruction status register bits [3:0] with the status. The data status and fault address registers keep their values.
- R11: In any cycle without an abort, all three fault registers keep their values.
- R12: `rd_sel` 0 returns the data status register, 1 the fault address register, 2 the instruction status register (each zero-extended) and 3 returns zero, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| mmu_en | input | 1 | Translation enable |
| align_en | input | 1 | Alignment check enable |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_addr | input | ADDR_W | Virtual address of the access |
| acc_domain | input | 4 | Domain number of the access |
| acc_kind | input | 2 | 0 plain, 1 uncached read, 2 unbuffered write, 3 locked swap |
| acc_linefetch | input | 1 | Access is a cache line fill |
| desc_is_page | input | 1 | Resolved through a page (1) or section (0) descriptor |
| flt_misalign | input | 1 | Address misaligned for the access size |
| flt_xlt | input | 1 | Translation fault flag |
| flt_dom | input | 1 | Domain fault flag |
| flt_perm | input | 1 | Permission fault flag |
| ext_walk_err | input | 1 | External error during the table walk |
| ext_bus_err | input | 1 | External error on the final access |
| bus_req | output | 1 | Outgoing bus request |
| abort | output | 1 | Abort to the core |
| abort_prefetch | output | 1 | The abort belongs to an instruction fetch |
| rd_sel | input | 2 | Register read select |
| rd_data | output | ADDR_W | Register read data |

## Verification
A wrong priority or encoding in the arbiter shows up in the same cycle only as a changed `abort` or `bus_req`. The wrong status code itself becomes visible one edge later, when the status register is read back. A corrupted register write-enable, such as a fetch abort touching the address register or a register loading without an abort, stays hidden until the next read of that register. The bench therefore reads all three registers back after every access, so that any such error is exposed within a few cycles of the access that caused it.

// File: rtl/mfu_pkg.sv
package mfu_pkg;

  localparam int N_SRC  = 6;
  localparam int DFSR_W = 8;
  localparam int IFSR_W = 4;

  // source index doubles as priority: lower index wins
  localparam int SRC_ALIGN = 0;
  localparam int SRC_WALK  = 1;
  localparam int SRC_XLT   = 2;
  localparam int SRC_DOM   = 3;
  localparam int SRC_PERM  = 4;
  localparam int SRC_EXT   = 5;

  typedef logic [3:0] fsc_t;

  localparam fsc_t FSC_NONE     = 4'b0000;
  localparam fsc_t FSC_ALIGN    = 4'b0001;
  localparam fsc_t FSC_XLT_SEC  = 4'b0101;
  localparam fsc_t FSC_XLT_PG   = 4'b0111;
  localparam fsc_t FSC_DOM_SEC  = 4'b1001;
  localparam fsc_t FSC_DOM_PG   = 4'b1011;
  localparam fsc_t FSC_PERM_SEC = 4'b1101;
  localparam fsc_t FSC_PERM_PG  = 4'b1111;
  localparam fsc_t FSC_EXT_LF   = 4'b0100;
  localparam fsc_t FSC_EXT_NLF  = 4'b1000;

  typedef enum logic [1:0] {
    ACC_PLAIN    = 2'd0,
    ACC_NC_READ  = 2'd1,
    ACC_NB_WRITE = 2'd2,
    ACC_SWAP     = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    RSEL_DFSR = 2'd0,
    RSEL_FAR  = 2'd1,
    RSEL_IFSR = 2'd2,
    RSEL_NONE = 2'd3
  } rsel_e;

  typedef struct packed {
    logic       hit;
    logic       violation;
    fsc_t       status;
    logic [3:0] domain;
  } fault_t;

endpackage

// File: rtl/mfu_qualify.sv
module mfu_qualify
  import mfu_pkg::*;
(
  input  logic             mmu_en,
  input  logic             align_en,
  input  logic             acc_valid,
  input  logic             acc_fetch,
  input  logic [1:0]       acc_kind,
  input  logic             flt_misalign,
  input  logic             flt_xlt,
  input  logic             flt_dom,
  input  logic             flt_perm,
  input  logic             ext_walk_err,
  input  logic             ext_bus_err,
  output logic [N_SRC-1:0] src_act
);

  logic sync_kind;

  always_comb begin
    // external errors only count when the core is stalled on the bus
    sync_kind = (acc_kind == ACC_NC_READ) || (acc_kind == ACC_NB_WRITE) ||
                (acc_kind == ACC_SWAP);

    src_act            = '0;
    src_act[SRC_ALIGN] = acc_valid && align_en && !acc_fetch && flt_misalign;
    src_act[SRC_WALK]  = acc_valid && mmu_en && ext_walk_err;
    src_act[SRC_XLT]   = acc_valid && mmu_en && flt_xlt;
    src_act[SRC_DOM]   = acc_valid && mmu_en && flt_dom;
    src_act[SRC_PERM]  = acc_valid && mmu_en && flt_perm;
    src_act[SRC_EXT]   = acc_valid && sync_kind && ext_bus_err;
  end

endmodule

// File: rtl/mfu_prio.sv
module mfu_prio
  import mfu_pkg::*;
(
  input  logic [N_SRC-1:0] src_act,
  input  logic             desc_is_page,
  input  logic             acc_linefetch,
  input  logic [3:0]       acc_domain,
  output fault_t           fault
);

  fsc_t       code [N_SRC];
  logic [3:0] dom  [N_SRC];

  always_comb begin
    code[SRC_ALIGN] = FSC_ALIGN;
    code[SRC_WALK]  = FSC_EXT_NLF;
    code[SRC_XLT]   = desc_is_page  ? FSC_XLT_PG  : FSC_XLT_SEC;
    code[SRC_DOM]   = desc_is_page  ? FSC_DOM_PG  : FSC_DOM_SEC;
    code[SRC_PERM]  = desc_is_page  ? FSC_PERM_PG : FSC_PERM_SEC;
    code[SRC_EXT]   = acc_linefetch ? FSC_EXT_LF  : FSC_EXT_NLF;

    dom[SRC_ALIGN] = 4'd0;
    dom[SRC_WALK]  = 4'd0;
    dom[SRC_XLT]   = 4'd0;
    dom[SRC_DOM]   = acc_domain;
    dom[SRC_PERM]  = acc_domain;
    dom[SRC_EXT]   = acc_domain;
  end

  // walk from least to most urgent so the most urgent active source lands last
  always_comb begin
    fault = '{hit: 1'b0, violation: 1'b0, status: FSC_NONE, domain: 4'd0};
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (src_act[i]) begin
        fault.hit    = 1'b1;
        fault.status = code[i];
        fault.domain = dom[i];
      end
    end
    // anything except the final-access bus error blocks the request
    fault.violation = |src_act[SRC_PERM:SRC_ALIGN];
  end

endmodule

// File: rtl/mfu_regs.sv
module mfu_regs
  import mfu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_data,
  input  logic              we_inst,
  input  fsc_t              status,
  input  logic [3:0]        domain,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        rd_sel,
  output logic [DFSR_W-1:0] dfsr_q,
  output logic [ADDR_W-1:0] far_q,
  output logic [IFSR_W-1:0] ifsr_q,
  output logic [ADDR_W-1:0] rd_data
);

  logic [DFSR_W-1:0] dfsr_d;
  logic [ADDR_W-1:0] far_d;
  logic [IFSR_W-1:0] ifsr_d;

  always_comb begin
    dfsr_d = {domain, status};
    far_d  = addr;
    ifsr_d = status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dfsr_q <= '0;
      far_q  <= '0;
    end else if (we_data) begin
      dfsr_q <= dfsr_d;
      far_q  <= far_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifsr_q <= '0;
    end else if (we_inst) begin
      ifsr_q <= ifsr_d;
    end
  end

  always_comb begin
    unique case (rsel_e'(rd_sel))
      RSEL_DFSR: rd_data = {{(ADDR_W-DFSR_W){1'b0}}, dfsr_q};
      RSEL_FAR:  rd_data = far_q;
      RSEL_IFSR: rd_data = {{(ADDR_W-IFSR_W){1'b0}}, ifsr_q};
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/mmu_fault_unit.sv
module mmu_fault_unit
  import mfu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmu_en,
  input  logic              align_en,
  input  logic              acc_valid,
  input  logic              acc_fetch,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_domain,
  input  logic [1:0]        acc_kind,
  input  logic              acc_linefetch,
  input  logic              desc_is_page,
  input  logic              flt_misalign,
  input  logic              flt_xlt,
  input  logic              flt_dom,
  input  logic              flt_perm,
  input  logic              ext_walk_err,
  input  logic              ext_bus_err,
  output logic              bus_req,
  output logic              abort,
  output logic              abort_prefetch,
  input  logic [1:0]        rd_sel,
  output logic [ADDR_W-1:0] rd_data
);

  logic [N_SRC-1:0]  src_act;
  fault_t            fault;
  logic              we_data;
  logic              we_inst;
  logic [DFSR_W-1:0] dfsr_q;
  logic [ADDR_W-1:0] far_q;
  logic [IFSR_W-1:0] ifsr_q;

  mfu_qualify u_qualify (
    .mmu_en       (mmu_en),
    .align_en     (align_en),
    .acc_valid    (acc_valid),
    .acc_fetch    (acc_fetch),
    .acc_kind     (acc_kind),
    .flt_misalign (flt_misalign),
    .flt_xlt      (flt_xlt),
    .flt_dom      (flt_dom),
    .flt_perm     (flt_perm),
    .ext_walk_err (ext_walk_err),
    .ext_bus_err  (ext_bus_err),
    .src_act      (src_act)
  );

  mfu_prio u_prio (
    .src_act       (src_act),
    .desc_is_page  (desc_is_page),
    .acc_linefetch (acc_linefetch),
    .acc_domain    (acc_domain),
    .fault         (fault)
  );

  always_comb begin
    abort          = fault.hit;
    abort_prefetch = fault.hit && acc_fetch;
    bus_req        = acc_valid && !fault.violation;
    we_data        = fault.hit && !acc_fetch;
    we_inst        = fault.hit && acc_fetch;
  end

  mfu_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_data (we_data),
    .we_inst (we_inst),
    .status  (fault.status),
    .domain  (fault.domain),
    .addr    (acc_addr),
    .rd_sel  (rd_sel),
    .dfsr_q  (dfsr_q),
    .far_q   (far_q),
    .ifsr_q  (ifsr_q),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/mfu_checker.sv
module mfu_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mmu_en,
  input logic              align_en,
  input logic              acc_valid,
  input logic              acc_fetch,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_kind,
  input logic              flt_misalign,
  input logic              flt_xlt,
  input logic              flt_dom,
  input logic              flt_perm,
  input logic              ext_walk_err,
  input logic              ext_bus_err,
  input logic              bus_req,
  input logic              abort,
  input logic [1:0]        rd_sel,
  input logic [ADDR_W-1:0] rd_data,
  input logic [7:0]        dfsr_q,
  input logic [ADDR_W-1:0] far_q,
  input logic [3:0]        ifsr_q
);

  a_r2_align_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_fetch && align_en && flt_misalign) |-> (abort && !bus_req));

  a_r3_fetch_no_align: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_fetch && !mmu_en && !ext_bus_err) |-> !abort);

  a_r4_mmu_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !mmu_en && !align_en && !ext_bus_err) |-> (!abort && bus_req));

  a_r6_sync_ext_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && ext_bus_err && acc_kind != 2'd0) |-> abort);

  a_r8_req_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || abort) |-> acc_valid);

  a_r8_violation_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mmu_en && (flt_xlt || flt_dom || flt_perm || ext_walk_err))
      |-> (abort && !bus_req));

  a_r9_far_load: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && abort && !acc_fetch) |=> (far_q == $past(acc_addr)));

  a_r10_fetch_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && abort && acc_fetch) |=> ($stable(far_q) && $stable(dfsr_q)));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !abort |=> ($stable(far_q) && $stable(dfsr_q) && $stable(ifsr_q)));

  a_r12_sel_none: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd3) |-> (rd_data == '0));

endmodule

bind mmu_fault_unit mfu_checker #(.ADDR_W(ADDR_W)) u_mfu_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .mmu_en       (mmu_en),
  .align_en     (align_en),
  .acc_valid    (acc_valid),
  .acc_fetch    (acc_fetch),
  .acc_addr     (acc_addr),
  .acc_kind     (acc_kind),
  .flt_misalign (flt_misalign),
  .flt_xlt      (flt_xlt),
  .flt_dom      (flt_dom),
  .flt_perm     (flt_perm),
  .ext_walk_err (ext_walk_err),
  .ext_bus_err  (ext_bus_err),
  .bus_req      (bus_req),
  .abort        (abort),
  .rd_sel       (rd_sel),
  .rd_data      (rd_data),
  .dfsr_q       (dfsr_q),
  .far_q        (far_q),
  .ifsr_q       (ifsr_q)
);

// File: tb/mmu_fault_unit_bench.sv
module mmu_fault_unit_bench;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mmu_en, align_en, acc_valid, acc_fetch;
  logic [AW-1:0] acc_addr;
  logic [3:0]    acc_domain;
  logic [1:0]    acc_kind;
  logic          acc_linefetch, desc_is_page;
  logic          flt_misalign, flt_xlt, flt_dom, flt_perm;
  logic          ext_walk_err, ext_bus_err;
  logic          bus_req, abort, abort_prefetch;
  logic [1:0]    rd_sel;
  logic [AW-1:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0]    m_dfsr;
  logic [AW-1:0] m_far;
  logic [3:0]    m_ifsr;

  always #2 clk = ~clk;

  mmu_fault_unit #(.ADDR_W(AW)) u_mmu_fault_unit (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .align_en(align_en),
    .acc_valid(acc_valid), .acc_fetch(acc_fetch), .acc_addr(acc_addr),
    .acc_domain(acc_domain), .acc_kind(acc_kind), .acc_linefetch(acc_linefetch),
    .desc_is_page(desc_is_page), .flt_misalign(flt_misalign), .flt_xlt(flt_xlt),
    .flt_dom(flt_dom), .flt_perm(flt_perm), .ext_walk_err(ext_walk_err),
    .ext_bus_err(ext_bus_err), .bus_req(bus_req), .abort(abort),
    .abort_prefetch(abort_prefetch), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    acc_valid = 0; acc_fetch = 0; acc_addr = '0; acc_domain = 0; acc_kind = 0;
    acc_linefetch = 0; desc_is_page = 0; flt_misalign = 0; flt_xlt = 0;
    flt_dom = 0; flt_perm = 0; ext_walk_err = 0; ext_bus_err = 0;
  endtask

  task automatic check_regs(input string req);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      rd_sel = 2'(s);
      #1;
      case (s)
        0: chk(req, "data status", rd_data, {24'd0, m_dfsr});
        1: chk(req, "fault address", rd_data, m_far);
        2: chk(req, "inst status", rd_data, {28'd0, m_ifsr});
        default: chk(req, "R12 unused select", rd_data, '0);
      endcase
    end
  endtask

  // expected outcome from the requirement text (R2-R8)
  task automatic access(input string req, input logic fetch, input logic [AW-1:0] addr,
                        input logic [3:0] dom, input logic [1:0] kind, input logic lf,
                        input logic page, input logic mis, input logic xlt,
                        input logic df, input logic pf, input logic walk, input logic ext);
    logic e_hit, e_viol;
    logic [3:0] e_st, e_dm;
    e_hit = 1; e_viol = 1; e_dm = 0; e_st = 0;
    if (!fetch && align_en && mis)      e_st = 4'b0001;
    else if (mmu_en && walk)            e_st = 4'b1000;
    else if (mmu_en && xlt)             e_st = page ? 4'b0111 : 4'b0101;
    else if (mmu_en && df) begin        e_st = page ? 4'b1011 : 4'b1001; e_dm = dom; end
    else if (mmu_en && pf) begin        e_st = page ? 4'b1111 : 4'b1101; e_dm = dom; end
    else if (ext && kind != 0) begin    e_st = lf ? 4'b0100 : 4'b1000; e_dm = dom; e_viol = 0; end
    else begin e_hit = 0; e_viol = 0; end

    @(negedge clk);
    acc_valid = 1; acc_fetch = fetch; acc_addr = addr; acc_domain = dom; acc_kind = kind;
    acc_linefetch = lf; desc_is_page = page; flt_misalign = mis; flt_xlt = xlt;
    flt_dom = df; flt_perm = pf; ext_walk_err = walk; ext_bus_err = ext;
    #1;
    chk(req, "abort", {31'd0, abort}, {31'd0, e_hit});
    chk(req, "R8 bus_req", {31'd0, bus_req}, {31'd0, !e_viol});
    chk(req, "abort_prefetch", {31'd0, abort_prefetch}, {31'd0, e_hit && fetch});
    @(negedge clk);
    clear_inputs();
    if (e_hit) begin
      if (fetch) m_ifsr = e_st;
      else begin m_dfsr = {e_dm, e_st}; m_far = addr; end
    end
    check_regs(req);
  endtask

  task automatic t_reset();
    check_regs("R1");
    chk("R1", "idle abort", {31'd0, abort}, 32'd0);
    chk("R1", "idle bus_req", {31'd0, bus_req}, 32'd0);
  endtask

  task automatic t_align();
    mmu_en = 0; align_en = 1;
    access("R2 R9", 0, 32'h1000_0002, 4'h5, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    access("R3 fetch", 1, 32'h2000_0001, 4'h5, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    mmu_en = 1;
    access("R2 mmu on", 0, 32'h1000_0103, 4'h2, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    align_en = 0; mmu_en = 0;
    access("R3 disabled", 0, 32'h3000_0001, 4'h5, 0, 0, 0, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_mmu_gate();
    mmu_en = 0; align_en = 0;
    access("R4 off", 0, 32'h4000_0000, 4'h3, 0, 0, 0, 0, 1, 1, 1, 0, 0);
    mmu_en = 1;
    access("R4 xlt sec", 0, 32'h4000_0010, 4'h3, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    access("R4 xlt pg",  0, 32'h4000_0020, 4'h3, 0, 0, 1, 0, 1, 0, 0, 0, 0);
    access("R4 dom sec", 0, 32'h4000_0030, 4'h7, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    access("R4 dom pg",  0, 32'h4000_0040, 4'h9, 0, 0, 1, 0, 0, 1, 0, 0, 0);
    access("R4 perm sec", 0, 32'h4000_0050, 4'hA, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    access("R4 perm pg", 0, 32'h4000_0060, 4'hC, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    access("R10 fetch perm", 1, 32'h5000_0000, 4'hC, 0, 0, 1, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_prio();
    mmu_en = 1; align_en = 1;
    access("R5 all",   0, 32'h6000_0001, 4'h6, 1, 1, 1, 1, 1, 1, 1, 1, 1);
    access("R5 walk",  0, 32'h6000_0002, 4'h6, 1, 1, 1, 0, 1, 1, 1, 1, 1);
    access("R5 xlt",   0, 32'h6000_0003, 4'h6, 1, 1, 1, 0, 1, 1, 1, 0, 1);
    access("R5 dom",   0, 32'h6000_0004, 4'h6, 1, 1, 0, 0, 0, 1, 1, 0, 1);
    access("R5 perm",  0, 32'h6000_0005, 4'h6, 1, 1, 0, 0, 0, 0, 1, 0, 1);
    access("R5 ext",   0, 32'h6000_0006, 4'h6, 1, 1, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_ext();
    mmu_en = 0; align_en = 0;
    access("R6 plain ignored", 0, 32'h7000_0000, 4'h4, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    access("R6 nc read", 0, 32'h7000_0004, 4'h4, 1, 0, 0, 0, 0, 0, 0, 0, 1);
    access("R6 nb write lf", 0, 32'h7000_0008, 4'hB, 2, 1, 0, 0, 0, 0, 0, 0, 1);
    access("R6 swap", 0, 32'h7000_000C, 4'hD, 3, 0, 0, 0, 0, 0, 0, 0, 1);
    access("R10 fetch ext", 1, 32'h7100_0000, 4'hE, 1, 1, 0, 0, 0, 0, 0, 0, 1);
    access("R7 walk mmu off", 0, 32'h7200_0000, 4'h1, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    mmu_en = 1;
    access("R7 walk", 0, 32'h7200_0004, 4'h1, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    access("R7 fetch walk", 1, 32'h7300_0000, 4'h1, 0, 0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_hold();
    mmu_en = 1; align_en = 1;
    access("R11 clean data", 0, 32'h8000_0000, 4'hF, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    access("R11 clean fetch", 1, 32'h8000_0004, 4'hF, 0, 1, 0, 1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    rst_n = 0; mmu_en = 0; align_en = 0; rd_sel = 0;
    clear_inputs();
    m_dfsr = 0; m_far = 0; m_ifsr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_align();
    t_mmu_gate();
    t_prio();
    t_ext();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule